// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches sixteen external input lines and turns their edges into interrupt requests for a processor's interrupt controller. Each line picks its signal from one of up to sixteen general-purpose input ports through a 4-bit source field. The selected signal passes through a two-flop synchroniser. A rising edge, a falling edge, or either edge sets the line's pending flag, depending on two per-line enable bits. Software clears a pending flag by writing a 1 to it. A per-line mask decides whether a pending line drives a request.

There are seven registered request outputs. Lines 0 to 4 each have their own output. Lines 5 to 9 share one output, and lines 10 to 15 share another. For a shared output, software reads the pending register to find the lines that caused the request and clears them one by one. All configuration goes through a small synchronous register bus with combinational read data.

Each line holds a two-state machine. From LINE_IDLE, the transition "edge hit" goes to LINE_PEND when an enabled edge is seen. From LINE_PEND, the transition "cleared" returns to LINE_IDLE on a write-1-to-clear in a cycle with no new hit. In every other case the line stays in its current state.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and all seven request outputs are low.
- R2: Register addresses: 0 to 3 hold the source fields (register k holds lines 4k to 4k+3, line n at bits 4*(n mod 4)+3 down to 4*(n mod 4)); 4 is the mask, 5 the rising enable, 6 the falling enable, 7 the pending register. Bit n of registers 4 to 7 belongs to line n. Written values read back unchanged.
- R3: Line n samples bit p*16+n of `gpio_in`, where p is its source field. A source value of NUM_PORTS or more selects a constant 0. Activity on the same pin of any other port has no effect on the line.
- R4: With the rising enable set, a 0-to-1 change on the selected input sets the pending bit, readable at the third clock edge after the change. A 1-to-0 change with only the rising enable set leaves the bit clear.
- R5: With the falling enable set, a 1-to-0 change on the selected input sets the pending bit.
- R6: With both enables set, either kind of change sets the pending bit.
- R7: With neither enable set, no change on the input sets the pending bit.
- R8: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R9: If a new enabled edge and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R10: A pending bit is recorded whatever the mask. A masked pending line drives no request.
- R11: `irq_out[n]` for n in 0 to 4 follows line n. `irq_out[5]` is the OR of lines 5 to 9 and `irq_out[6]` the OR of lines 10 to 15, each taking pending AND mask. Each output rises one clock after its term becomes true.
- R12: A shared output stays high while any unmasked line of its group is still pending. It falls in the clock after the write that clears the last such line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | NUM_PORTS*16 | Raw port inputs, port p pin n at bit p*16+n |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq_out | output | 7 | Registered interrupt requests |

## Verification
The hardest case to reach is the collision: a clearing write must land in exactly the cycle in which the synchronised edge is detected. The bench moves the input at a known falling clock edge. It counts two rising edges through the synchroniser and then holds the write so that it is sampled on the third edge, the same edge at which the pending flag is loaded. A second timing-sensitive case is a shared output with two pending lines. The bench clears them one at a time and checks the output at the exact clock after each write.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
    localparam int NUM_LINES  = 16;
    localparam int SEL_W      = 4;
    localparam int NUM_SRC    = 1 << SEL_W;
    localparam int REG_W      = NUM_LINES;
    localparam int ADDR_W     = 3;
    localparam int FIELDS_PER = REG_W / SEL_W;
    localparam int NUM_SELREG = NUM_LINES / FIELDS_PER;
    localparam int DIRECT_N   = 5;
    localparam int GA_LO      = 5;
    localparam int GA_HI      = 9;
    localparam int GB_LO      = 10;
    localparam int GB_HI      = 15;
    localparam int NUM_IRQ    = DIRECT_N + 2;

    typedef enum logic [ADDR_W-1:0] {
        AD_SEL0 = 3'd0,
        AD_SEL1 = 3'd1,
        AD_SEL2 = 3'd2,
        AD_SEL3 = 3'd3,
        AD_MASK = 3'd4,
        AD_RISE = 3'd5,
        AD_FALL = 3'd6,
        AD_PEND = 3'd7
    } reg_addr_e;

    typedef enum logic {
        LINE_IDLE = 1'b0,
        LINE_PEND = 1'b1
    } line_state_e;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise_ev,
    output logic [W-1:0] fall_ev
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_ev = sync_q & ~prev_q;
    assign fall_ev = ~sync_q & prev_q;
endmodule

// File: rtl/edge_irq_line.sv
module edge_irq_line
    import edge_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_ev,
    input  logic fall_ev,
    input  logic rise_en,
    input  logic fall_en,
    input  logic clr,
    output logic pend
);
    line_state_e st_q, st_d;
    logic        hit;

    assign hit = (rise_ev & rise_en) | (fall_ev & fall_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LINE_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LINE_IDLE: if (hit)         st_d = LINE_PEND;
            LINE_PEND: if (clr && !hit) st_d = LINE_IDLE;
            default:                    st_d = LINE_IDLE;
        endcase
    end

    always_comb pend = (st_q == LINE_PEND);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend);
    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && clr && !hit) |=> !pend);
    // R7
    no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_en && !fall_en && !pend) |=> !pend);
endmodule

// File: rtl/edge_irq_req.sv
module edge_irq_req
    import edge_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend,
    input  logic [NUM_LINES-1:0] mask,
    output logic [NUM_IRQ-1:0]   irq_out
);
    logic [NUM_LINES-1:0] live;
    logic [NUM_IRQ-1:0]   raw;

    assign live = pend & mask;

    for (genvar i = 0; i < DIRECT_N; i++) begin : g_direct
        assign raw[i] = live[i];
    end
    assign raw[DIRECT_N]   = |live[GA_HI:GA_LO];
    assign raw[DIRECT_N+1] = |live[GB_HI:GB_LO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= raw;
    end

    // R11
    grp_a_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend[GA_HI:GA_LO] & mask[GA_HI:GA_LO])) |=> irq_out[DIRECT_N]);
    // R12
    grp_b_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend[GB_HI:GB_LO] & mask[GB_HI:GB_LO])) |=> !irq_out[DIRECT_N+1]);
    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && !mask[0]) |=> !irq_out[0]);
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import edge_irq_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS*NUM_LINES-1:0] gpio_in,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_wr,
    input  logic [REG_W-1:0]               bus_wdata,
    output logic [REG_W-1:0]               bus_rdata,
    output logic [NUM_IRQ-1:0]             irq_out
);
    logic [NUM_LINES-1:0][SEL_W-1:0] sel_q;
    logic [NUM_LINES-1:0]            mask_q, rise_q, fall_q;
    logic [NUM_LINES-1:0]            src, rise_ev, fall_ev, pend, clr;
    logic [NUM_SELREG-1:0][REG_W-1:0] sel_word;

    // Configuration registers
    for (genvar k = 0; k < NUM_SELREG; k++) begin : g_selreg
        for (genvar j = 0; j < FIELDS_PER; j++) begin : g_field
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    sel_q[k*FIELDS_PER+j] <= '0;
                else if (bus_wr && bus_addr == ADDR_W'(k))
                    sel_q[k*FIELDS_PER+j] <= bus_wdata[j*SEL_W +: SEL_W];
            end
            assign sel_word[k][j*SEL_W +: SEL_W] = sel_q[k*FIELDS_PER+j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == AD_MASK) mask_q <= bus_wdata;
            if (bus_addr == AD_RISE) rise_q <= bus_wdata;
            if (bus_addr == AD_FALL) fall_q <= bus_wdata;
        end
    end

    assign clr = (bus_wr && bus_addr == AD_PEND) ? bus_wdata : '0;

    // Source selection: pin n of the chosen port, zero beyond NUM_PORTS
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_src
        logic [NUM_SRC-1:0] cand;
        for (genvar p = 0; p < NUM_SRC; p++) begin : g_port
            if (p < NUM_PORTS) begin : g_real
                assign cand[p] = gpio_in[p*NUM_LINES+n];
            end else begin : g_none
                assign cand[p] = 1'b0;
            end
        end
        assign src[n] = cand[sel_q[n]];
    end

    edge_irq_sync #(.W(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (src),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        edge_irq_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise_ev (rise_ev[n]),
            .fall_ev (fall_ev[n]),
            .rise_en (rise_q[n]),
            .fall_en (fall_q[n]),
            .clr     (clr[n]),
            .pend    (pend[n])
        );
    end

    edge_irq_req u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .mask    (mask_q),
        .irq_out (irq_out)
    );

    always_comb begin
        unique case (bus_addr)
            AD_SEL0: bus_rdata = sel_word[0];
            AD_SEL1: bus_rdata = sel_word[1];
            AD_SEL2: bus_rdata = sel_word[2];
            AD_SEL3: bus_rdata = sel_word[3];
            AD_MASK: bus_rdata = mask_q;
            AD_RISE: bus_rdata = rise_q;
            AD_FALL: bus_rdata = fall_q;
            AD_PEND: bus_rdata = pend;
            default: bus_rdata = '0;
        endcase
    end

    // R2
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AD_MASK) |=> (mask_q == $past(bus_wdata)));
endmodule

// File: tb/edge_irq_ctrl_bench.sv
module edge_irq_ctrl_bench;
    localparam int NP = 4;
    localparam int NL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP*NL-1:0] gpio_in = '0;
    logic [2:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic [6:0]    irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    edge_irq_ctrl #(.NUM_PORTS(NP)) u_edge_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // Vector: [19:16] req, [15:12] line, [11:8] sel, [7:4] drive port,
    //         [3] rise en, [2] fall en, [1] start level, [0] expect pending
    localparam logic [19:0] VEC [0:8] = '{
        {4'd4, 4'd0,  4'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 rising
        {4'd5, 4'd3,  4'd2, 4'd2, 1'b0, 1'b1, 1'b1, 1'b1}, // R5 falling
        {4'd6, 4'd7,  4'd1, 4'd1, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 rise of both
        {4'd6, 4'd7,  4'd1, 4'd1, 1'b1, 1'b1, 1'b1, 1'b1}, // R6 fall of both
        {4'd4, 4'd9,  4'd3, 4'd3, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 fall ignored
        {4'd3, 4'd12, 4'd2, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 other port
        {4'd7, 4'd15, 4'd3, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 no trigger
        {4'd3, 4'd10, 4'd5, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 sel >= ports
        {4'd5, 4'd5,  4'd1, 4'd1, 1'b0, 1'b1, 1'b1, 1'b1}  // R5 falling
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reg", d, 16'h0000);
        end
        chk("R1 irq", {9'd0, irq_out}, 16'h0000);

        // R2 readback
        wr(3'd2, 16'hABCD);
        rd(3'd2, d); chk("R2 sel2", d, 16'hABCD);
        wr(3'd4, 16'h1234);
        rd(3'd4, d); chk("R2 mask", d, 16'h1234);
        wr(3'd4, 16'h0000);

        // Table walk
        for (int i = 0; i < 9; i++) begin
            logic [19:0] v;
            int ln, idx;
            v  = VEC[i];
            ln = int'(v[15:12]);
            idx = int'(v[7:4]) * NL + ln;
            for (int k = 0; k < 4; k++)
                wr(3'(k), (k == ln / 4) ? (16'(v[11:8]) << (4 * (ln % 4))) : 16'h0);
            wr(3'd5, 16'(v[3]) << ln);
            wr(3'd6, 16'(v[2]) << ln);
            gpio_in = '0;
            gpio_in[idx] = v[1];
            repeat (4) @(negedge clk);
            wr(3'd7, 16'hFFFF);
            gpio_in[idx] = ~v[1];
            repeat (3) @(negedge clk);
            rd(3'd7, d);
            checks++;
            if (d !== (16'(v[0]) << ln)) begin
                fails++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h",
                         v[19:16], i, d, 16'(v[0]) << ln);
            end
        end

        // Directed setup: all lines on port 0, rising only, masked
        for (int k = 0; k < 4; k++) wr(3'(k), 16'h0);
        wr(3'd6, 16'h0000);
        wr(3'd5, 16'hFFFF);
        gpio_in = '0;
        repeat (4) @(negedge clk);
        wr(3'd7, 16'hFFFF);

        // R8 write-1-to-clear
        gpio_in[0] = 1'b1; gpio_in[1] = 1'b1;
        repeat (3) @(negedge clk);
        rd(3'd7, d); chk("R4 two lines", d, 16'h0003);
        wr(3'd7, 16'h0001);
        rd(3'd7, d); chk("R8 clear one", d, 16'h0002);
        wr(3'd7, 16'h0000);
        rd(3'd7, d); chk("R8 zero keeps", d, 16'h0002);

        // R10 masked pending gives no request
        chk("R10 masked", {9'd0, irq_out}, 16'h0000);
        wr(3'd4, 16'h0002);
        chk("R11 not yet", {9'd0, irq_out}, 16'h0000);
        @(negedge clk);
        chk("R10 unmasked", {9'd0, irq_out}, 16'h0002);
        wr(3'd7, 16'hFFFF);
        @(negedge clk);

        // R11 direct and grouped outputs
        wr(3'd4, 16'hFFFF);
        @(negedge clk);
        chk("R11 idle", {9'd0, irq_out}, 16'h0000);
        gpio_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 line3", {9'd0, irq_out}, 16'h0008);
        wr(3'd7, 16'h0008);
        @(negedge clk);
        chk("R11 line3 drop", {9'd0, irq_out}, 16'h0000);
        gpio_in[6] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 group a", {9'd0, irq_out}, 16'h0020);
        gpio_in[8] = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd7, d); chk("R11 pend 6 8", d, 16'h0140);

        // R12 shared output holds until the last line clears
        wr(3'd7, 16'h0040);
        @(negedge clk);
        chk("R12 held", {9'd0, irq_out}, 16'h0020);
        wr(3'd7, 16'h0100);
        chk("R12 one more clk", {9'd0, irq_out}, 16'h0020);
        @(negedge clk);
        chk("R12 dropped", {9'd0, irq_out}, 16'h0000);
        gpio_in[13] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 group b", {9'd0, irq_out}, 16'h0040);
        wr(3'd7, 16'hFFFF);

        // R9 edge and clear in the same cycle
        wr(3'd6, 16'hFFFF);
        gpio_in[2] = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd7, d); chk("R9 setup", d & 16'h0004, 16'h0004);
        gpio_in[2] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 3'd7; bus_wdata = 16'h0004; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(3'd7, d); chk("R9 set wins", d & 16'h0004, 16'h0004);
        wr(3'd7, 16'h0004);
        rd(3'd7, d); chk("R8 after collision", d & 16'h0004, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule